// File: doc/BRIEF.md
# Supervisory reset pulse generator

This block produces a system reset from two conditions: a supply-good flag and a manual reset request. The supply flag comes from a comparator and is already synchronous to the clock. The manual request is active low, may arrive from a push-button or from other logic, and is treated as asynchronous. Reset is asserted for as long as either condition is present. Once both conditions have cleared, reset is held for a fixed number of clock cycles before it is released. A trigger that lasts only one sampled cycle still yields a reset pulse of full width.

The hold length is the parameter `HOLD_CYCLES`, counted in clock cycles, so a bench can use a short value where silicon would use tens of milliseconds. An active-low power-on clear input (`por_n`) forces the block into its asserted state asynchronously. That state then runs one full hold before the first release. A watchdog has no path into this block. A timeout can reset the system only if the watchdog's output is wired to the manual request input outside the block. Both reset outputs come from registers, so neither can glitch.

Top module: `supv_reset_gen`

## Requirements
- R1: While `por_n` is low, `rst_n_o` is 0 and `rst_o` is 1, taking effect without waiting for a clock edge. After `por_n` rises, reset stays asserted until a full hold has completed.
- R2: `rst_o` is always the exact complement of `rst_n_o`.
- R3: If `supply_ok` is sampled 0 at a rising edge, `rst_n_o` is 0 after that edge. It remains 0 for as long as `supply_ok` stays 0.
- R4: After supply recovery, `rst_n_o` rises exactly `HOLD_CYCLES` rising edges after the last edge at which `supply_ok` was sampled 0.
- R5: `man_rst_n` passes through a two-flop synchroniser. If it is sampled 0 at rising edge k, `rst_n_o` is 0 after edge k+2.
- R6: After `man_rst_n` is released (0 to 1), `rst_n_o` rises exactly `HOLD_CYCLES` rising edges after the last edge at which the synchronised request was still 0.
- R7: A trigger seen at a single edge (a one-cycle supply dip, or a one-cycle manual pulse) gives a reset low pulse of exactly `HOLD_CYCLES` cycles.
- R8: A trigger that reappears during the hold restarts the count. Release then comes `HOLD_CYCLES` edges after the newest trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on clear, active low |
| supply_ok | input | 1 | Supply above threshold, synchronous to `clk`, 1 = good |
| man_rst_n | input | 1 | Manual reset request, active low, asynchronous |
| rst_n_o | output | 1 | System reset, active low |
| rst_o | output | 1 | System reset, active high, complement of `rst_n_o` |

## Verification
The assertions assume that `supply_ok` only changes away from the rising clock edge. They also assume that `por_n` is released away from an edge, since only its assertion is asynchronous. Nothing is assumed about `man_rst_n`, because the synchroniser absorbs its timing. The bench drives every input on the falling edge. It also pulls `por_n` low at an off-edge instant in the middle of a run, so that all inputs stay inside these assumptions. The bench's reference model counts clock edges since the last trigger and compares the outputs on every cycle.

// File: rtl/supv_pkg.sv
package supv_pkg;
  // number of flops in the manual-request synchroniser
  localparam int unsigned SYNC_DEPTH = 2;

  // counter width able to hold the value n
  function automatic int unsigned ctr_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        INIT_VAL = 1'b0
) (
  input  logic clk,
  input  logic por_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) sh_q <= INIT_VAL;
        else        sh_q <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) sh_q <= {STAGES{INIT_VAL}};
        else        sh_q <= {sh_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = sh_q[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk2
      // R5: a sampled request level appears at the output two edges later
      assert_sync_low_R5: assert property (@(posedge clk) disable iff (!por_n)
        !din |-> ##2 !dout);
      assert_sync_high_R5: assert property (@(posedge clk) disable iff (!por_n)
        din |-> ##2 dout);
    end
  endgenerate
endmodule

// File: rtl/supv_hold_ctr.sv
module supv_hold_ctr #(
  parameter int unsigned HOLD_CYCLES = 16,
  localparam int unsigned CW = supv_pkg::ctr_width(HOLD_CYCLES)
) (
  input  logic clk,
  input  logic por_n,
  input  logic trig,
  output logic release_nxt
);
  localparam logic [CW-1:0] HOLD_LD = CW'(HOLD_CYCLES);
  localparam logic [CW-1:0] ONE     = CW'(1);

  logic [CW-1:0] cnt_q;

  // load on any trigger, count down otherwise
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)            cnt_q <= HOLD_LD;
    else if (trig)         cnt_q <= HOLD_LD;
    else if (cnt_q != '0)  cnt_q <= cnt_q - ONE;
  end

  // release only when this edge ends the hold and no trigger is present
  assign release_nxt = !trig && (cnt_q <= ONE);

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!por_n)
    cnt_q <= HOLD_LD);
  // R8: a trigger always reloads the hold, so the next release is a full hold away
  assert_reload_R8: assert property (@(posedge clk) disable iff (!por_n)
    trig |=> !release_nxt || (HOLD_CYCLES <= 1));
endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen #(
  parameter int unsigned HOLD_CYCLES = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic supply_ok,
  input  logic man_rst_n,
  output logic rst_n_o,
  output logic rst_o
);
  logic man_sync_n;
  logic trig;
  logic release_nxt;
  logic rst_n_q;
  logic rst_q;

  supv_sync #(
    .STAGES  (supv_pkg::SYNC_DEPTH),
    .INIT_VAL(1'b0)
  ) u_sync (
    .clk  (clk),
    .por_n(por_n),
    .din  (man_rst_n),
    .dout (man_sync_n)
  );

  assign trig = !supply_ok || !man_sync_n;

  supv_hold_ctr #(
    .HOLD_CYCLES(HOLD_CYCLES)
  ) u_hold (
    .clk        (clk),
    .por_n      (por_n),
    .trig       (trig),
    .release_nxt(release_nxt)
  );

  // two separate output flops, each glitch-free
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rst_n_q <= 1'b0;
      rst_q   <= 1'b1;
    end else begin
      rst_n_q <= release_nxt;
      rst_q   <= !release_nxt;
    end
  end

  assign rst_n_o = rst_n_q;
  assign rst_o   = rst_q;

  assert_complement_R2: assert property (@(posedge clk) disable iff (!por_n)
    rst_o != rst_n_o);
  assert_supply_bad_R3: assert property (@(posedge clk) disable iff (!por_n)
    !supply_ok |=> !rst_n_o);
  assert_release_quiet_R4: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_n_o) |-> !$past(trig));
  assert_manual_hold_R6: assert property (@(posedge clk) disable iff (!por_n)
    !man_sync_n |=> !rst_n_o);
endmodule

// File: tb/supv_reset_gen_tb_top.sv
module supv_reset_gen_tb_top;
  localparam int CLK_P = 10;
  localparam int HOLD  = 12;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic supply_ok = 1'b1;
  logic man_rst_n = 1'b1;
  logic rst_n_o, rst_o;

  int total = 0;
  int bad = 0;
  bit running = 1'b0;
  string phase = "R1";

  // reference model state
  int m_s1 = 0, m_s2 = 0;
  int since = 0;

  always #(CLK_P/2) clk = ~clk;

  supv_reset_gen #(.HOLD_CYCLES(HOLD)) dut_i (
    .clk(clk), .por_n(por_n), .supply_ok(supply_ok),
    .man_rst_n(man_rst_n), .rst_n_o(rst_n_o), .rst_o(rst_o)
  );

  // behavioural model: edges elapsed since the last trigger was seen
  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_s1 <= 0; m_s2 <= 0; since <= 0;
    end else begin
      if (!supply_ok || m_s2 == 0) since <= 0;
      else if (since < HOLD) since <= since + 1;
      m_s2 <= m_s1;
      m_s1 <= man_rst_n ? 1 : 0;
    end
  end

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  // compare on every cycle
  always @(negedge clk) begin
    if (running) begin
      automatic int exp_n = (por_n && since >= HOLD) ? 1 : 0;
      chk(por_n ? phase : "R1", rst_n_o == exp_n, rst_n_o, exp_n);
      chk("R2", rst_o == !rst_n_o, rst_o, !rst_n_o);
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic low_width(input string req, input int exp);
    int w = 0;
    for (int i = 0; i < 4*HOLD; i++) begin
      @(negedge clk);
      if (!rst_n_o) w++;
      else if (w > 0) break;
    end
    chk(req, w == exp, w, exp);
  endtask

  initial begin
    #(CLK_P*100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    running = 1'b1;
    phase = "R1";
    cyc(3);
    chk("R1", rst_n_o == 0 && rst_o == 1, rst_n_o, 0);
    por_n = 1'b1;
    cyc(HOLD + 6);
    chk("R1", rst_n_o == 1, rst_n_o, 1);

    phase = "R3";
    supply_ok = 1'b0;
    cyc(20);
    chk("R3", rst_n_o == 0, rst_n_o, 0);
    phase = "R4";
    supply_ok = 1'b1;
    cyc(HOLD - 1);
    chk("R4", rst_n_o == 0, rst_n_o, 0);
    cyc(2);
    chk("R4", rst_n_o == 1, rst_n_o, 1);
    cyc(3);

    phase = "R5";
    man_rst_n = 1'b0;
    cyc(2);
    chk("R5", rst_n_o == 1, rst_n_o, 1);
    cyc(1);
    chk("R5", rst_n_o == 0, rst_n_o, 0);
    cyc(8);
    phase = "R6";
    man_rst_n = 1'b1;
    cyc(HOLD + 1);
    chk("R6", rst_n_o == 0, rst_n_o, 0);
    cyc(2);
    chk("R6", rst_n_o == 1, rst_n_o, 1);
    cyc(3);

    phase = "R7";
    supply_ok = 1'b0;
    @(negedge clk); supply_ok = 1'b1;
    low_width("R7", HOLD - 1);
    cyc(4);
    man_rst_n = 1'b0;
    @(negedge clk); man_rst_n = 1'b1;
    low_width("R7", HOLD);
    cyc(4);

    phase = "R8";
    supply_ok = 1'b0;
    @(negedge clk); supply_ok = 1'b1;
    cyc(HOLD/2);
    supply_ok = 1'b0;
    @(negedge clk); supply_ok = 1'b1;
    cyc(HOLD - 1);
    chk("R8", rst_n_o == 0, rst_n_o, 0);
    cyc(2);
    chk("R8", rst_n_o == 1, rst_n_o, 1);
    cyc(3);

    phase = "R1";
    #(CLK_P/4);
    por_n = 1'b0;
    #1;
    chk("R1", rst_n_o == 0 && rst_o == 1, rst_n_o, 0);
    cyc(2);
    por_n = 1'b1;
    cyc(HOLD + 4);
    chk("R1", rst_n_o == 1, rst_n_o, 1);

    running = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule